// File: doc/BRIEF.md
# Edge-Triggered GPIO Interrupt Bank with Debounce

This block turns a bank of general-purpose input pins into a single interrupt request. Each pin has its own control word that chooses which edges are of interest and whether the pin first passes through a debounce filter. A detected edge sets a sticky status bit for that pin. A mask register decides which pending pins may drive the shared interrupt line.

Software writes ones to clear status bits. Separate write ports set and clear mask bits, so no read-modify-write is needed. The debounce filter counts an externally supplied millisecond tick. A pin's filtered value only follows the raw input once the raw input has disagreed with it for 2^n consecutive ticks, where n is the pin's debounce-length code. Only edges trigger interrupts; level triggering is not provided.

Top module: `gpio_edge_irq_bank`

## Requirements
- R1: After reset all status bits are 0, every mask bit is 1 and `irq_o` is 0.
- R2: Control-word bits 4:3 choose the edge: 0 detects nothing, 1 detects rising edges, 2 detects falling edges, 3 detects both. Control-word bits 2:0 are ignored.
- R3: A detected edge sets the pin's status bit, which stays set until cleared and latches even while the pin is masked. With debounce off, the bit appears on `status_o` two clock edges after the pin changes.
- R4: A status-clear write clears exactly the status bits written as one and leaves the bits written as zero unchanged.
- R5: When an edge and a status-clear for the same pin fall on the same clock edge, the status bit ends up set.
- R6: A mask-set write sets the mask bits written as one, and a mask-clear write clears them. When the same bit is on both ports in the same cycle, it ends up masked.
- R7: `irq_o` is registered and equals the OR over all pins of status AND NOT mask. It changes on the same edge as the status or mask change, so unmasking a pending pin raises it at once.
- R8: Control-word bit 8 enables debounce, and bits 7:5 hold a code n (0..7). With debounce on, the filtered input takes a new raw value only on the 2^n-th consecutive tick at which the raw input differs from it. A return to the filtered value restarts the count, and without ticks the filtered value never changes.
- R9: With debounce off, the filtered input follows the raw input after one clock, and the tick and length code have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| pin_raw | input | NPINS | Pin input levels, synchronous to clk |
| cfg_we | input | 1 | Write enable for one pin's control word |
| cfg_pin | input | IDX_W | Pin index of the control-word write |
| cfg_word | input | 9 | Control word: bit 8 debounce on, 7:5 length code, 4:3 edge select |
| stat_clr_we | input | 1 | Status-clear write strobe |
| stat_clr_bits | input | NPINS | Ones select status bits to clear |
| mask_set_we | input | 1 | Mask-set write strobe |
| mask_set_bits | input | NPINS | Ones select mask bits to set |
| mask_clr_we | input | 1 | Mask-clear write strobe |
| mask_clr_bits | input | NPINS | Ones select mask bits to clear |
| status_o | output | NPINS | Sticky per-pin edge status |
| mask_o | output | NPINS | Per-pin mask, 1 = masked |
| irq_o | output | 1 | Bank interrupt request |

## Verification
A corrupted edge-history register shows up as a spurious or missing bit on `status_o` two edges after the pin moves. A debounce counter that is off by one moves the status bit by exactly one tick period, which the tick-by-tick sweep over several length codes catches. A wrong mask or status bit is visible on `mask_o` or `status_o` on the very next edge, and `irq_o` disagrees with them on that same edge. The race between a clear and a new edge is exercised on the exact edge where both land.

// File: rtl/gei_pkg.sv
`timescale 1ns/1ps
package gei_pkg;
  localparam int CW_W      = 9;
  localparam int EDGE_LSB  = 3;
  localparam int EDGE_W    = 2;
  localparam int DBLEN_LSB = 5;
  localparam int DBLEN_W   = 3;
  localparam int DBEN_BIT  = 8;

  typedef enum logic [EDGE_W-1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_sel_e;

  typedef struct packed {
    logic               db_en;
    logic [DBLEN_W-1:0] db_len;
    edge_sel_e          edge_sel;
  } pin_cfg_t;

  function automatic pin_cfg_t unpack_cfg(input logic [CW_W-1:0] w);
    pin_cfg_t c;
    c.db_en    = w[DBEN_BIT];
    c.db_len   = w[DBLEN_LSB +: DBLEN_W];
    c.edge_sel = edge_sel_e'(w[EDGE_LSB +: EDGE_W]);
    return c;
  endfunction
endpackage

// File: rtl/gei_debounce.sv
`timescale 1ns/1ps
module gei_debounce #(
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             raw,
  input  logic             db_en,
  input  logic [LEN_W-1:0] db_len,
  output logic             filt_o
);
  localparam int CNT_W = (1 << LEN_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             filt_q;

  assign limit  = CNT_W'((1 << db_len) - 1);
  assign filt_o = filt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!db_en) begin
      filt_q <= raw;
      cnt_q  <= '0;
    end else if (raw == filt_q) begin
      cnt_q  <= '0;
    end else if (tick) begin
      if (cnt_q >= limit) begin
        filt_q <= raw;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  // R8: with the filter on, nothing moves the output between ticks
  a_r8_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
    (db_en && !tick) |=> $stable(filt_q));

  // R8: the output only ever moves toward the raw level
  a_r8_moves_to_raw: assert property (@(posedge clk) disable iff (rst)
    (db_en && (raw == filt_q)) |=> $stable(filt_q));

  // R9: with the filter off the output is the raw input one clock later
  a_r9_bypass_follows: assert property (@(posedge clk) disable iff (rst)
    !db_en |=> (filt_q == $past(raw)));
endmodule

// File: rtl/gei_edge_detect.sv
`timescale 1ns/1ps
module gei_edge_detect
  import gei_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      filt,
  input  edge_sel_e sel,
  output logic      hit_o
);
  logic prev_q;
  logic rise;
  logic fall;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= filt;
  end

  assign rise = filt & ~prev_q;
  assign fall = ~filt & prev_q;

  always_comb begin
    unique case (sel)
      EDGE_RISE: hit_o = rise;
      EDGE_FALL: hit_o = fall;
      EDGE_BOTH: hit_o = rise | fall;
      default:   hit_o = 1'b0;
    endcase
  end

  // R2: a hit only happens when the filtered level has just changed
  a_r2_hit_needs_change: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> (filt != $past(filt)));

  // R2: rising-only selection never reports a falling level
  a_r2_rise_is_high: assert property (@(posedge clk) disable iff (rst)
    (hit_o && sel == EDGE_RISE) |-> filt);

  // R2: falling-only selection never reports a rising level
  a_r2_fall_is_low: assert property (@(posedge clk) disable iff (rst)
    (hit_o && sel == EDGE_FALL) |-> !filt);
endmodule

// File: rtl/gei_status_mask.sv
`timescale 1ns/1ps
module gei_status_mask #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] set_vec,
  input  logic             clr_we,
  input  logic [NPINS-1:0] clr_bits,
  input  logic             mset_we,
  input  logic [NPINS-1:0] mset_bits,
  input  logic             mclr_we,
  input  logic [NPINS-1:0] mclr_bits,
  output logic [NPINS-1:0] status_o,
  output logic [NPINS-1:0] mask_o,
  output logic             irq_o
);
  logic [NPINS-1:0] status_q, status_d;
  logic [NPINS-1:0] mask_q, mask_d;
  logic [NPINS-1:0] clr_eff, mset_eff, mclr_eff;
  logic             irq_q;

  assign clr_eff  = clr_we  ? clr_bits  : '0;
  assign mset_eff = mset_we ? mset_bits : '0;
  assign mclr_eff = mclr_we ? mclr_bits : '0;

  // new edges are OR-ed in after the clear, so a coincident edge survives
  assign status_d = (status_q & ~clr_eff) | set_vec;
  assign mask_d   = (mask_q & ~mclr_eff) | mset_eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      mask_q   <= '1;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      mask_q   <= mask_d;
      irq_q    <= |(status_d & ~mask_d);
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = irq_q;

  // R1: reset state
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (status_q == '0 && mask_q == '1 && !irq_q));

  // R3: status bits never drop without a clear write
  a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
    !clr_we |=> (($past(status_q) & ~status_q) == '0));

  // R4: a clear write empties the selected bits that had no new edge
  a_r4_clear_done: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((status_q & $past(clr_bits & ~set_vec)) == '0));

  // R5: an edge always lands, even beside a clear
  a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
    (|set_vec) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

  // R6: mask bits only rise through the set port
  a_r6_mask_rise_by_set: assert property (@(posedge clk) disable iff (rst)
    !mset_we |=> ((mask_q & ~$past(mask_q)) == '0));

  // R6: the set port wins over the clear port
  a_r6_mask_set_wins: assert property (@(posedge clk) disable iff (rst)
    mset_we |=> ((mask_q & $past(mset_bits)) == $past(mset_bits)));

  // R7: interrupt line agrees with the registered status and mask
  a_r7_irq_consistent: assert property (@(posedge clk) disable iff (rst)
    irq_q == (|(status_q & ~mask_q)));
endmodule

// File: rtl/gpio_edge_irq_bank.sv
`timescale 1ns/1ps
module gpio_edge_irq_bank
  import gei_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ms_tick,
  input  logic [NPINS-1:0] pin_raw,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_pin,
  input  logic [CW_W-1:0]  cfg_word,
  input  logic             stat_clr_we,
  input  logic [NPINS-1:0] stat_clr_bits,
  input  logic             mask_set_we,
  input  logic [NPINS-1:0] mask_set_bits,
  input  logic             mask_clr_we,
  input  logic [NPINS-1:0] mask_clr_bits,
  output logic [NPINS-1:0] status_o,
  output logic [NPINS-1:0] mask_o,
  output logic             irq_o
);
  pin_cfg_t         cfg_new;
  pin_cfg_t         cfg_q [NPINS];
  logic [NPINS-1:0] filt;
  logic [NPINS-1:0] hit;
  logic             unused_cfg_low;

  assign cfg_new        = unpack_cfg(cfg_word);
  assign unused_cfg_low = ^cfg_word[EDGE_LSB-1:0];

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[i] <= '0;
      end else if (cfg_we && (cfg_pin == IDX_W'(i))) begin
        cfg_q[i] <= cfg_new;
      end
    end

    gei_debounce #(.LEN_W(DBLEN_W)) u_db (
      .clk    (clk),
      .rst    (rst),
      .tick   (ms_tick),
      .raw    (pin_raw[i]),
      .db_en  (cfg_q[i].db_en),
      .db_len (cfg_q[i].db_len),
      .filt_o (filt[i])
    );

    gei_edge_detect u_edge (
      .clk   (clk),
      .rst   (rst),
      .filt  (filt[i]),
      .sel   (cfg_q[i].edge_sel),
      .hit_o (hit[i])
    );

    // R2: a pin whose edge selection is off never raises its status bit
    a_r2_off_pin_quiet: assert property (@(posedge clk) disable iff (rst)
      (cfg_q[i].edge_sel == EDGE_OFF && !status_o[i]) |=> !status_o[i]);
  end

  gei_status_mask #(.NPINS(NPINS)) u_stat (
    .clk       (clk),
    .rst       (rst),
    .set_vec   (hit),
    .clr_we    (stat_clr_we),
    .clr_bits  (stat_clr_bits),
    .mset_we   (mask_set_we),
    .mset_bits (mask_set_bits),
    .mclr_we   (mask_clr_we),
    .mclr_bits (mask_clr_bits),
    .status_o  (status_o),
    .mask_o    (mask_o),
    .irq_o     (irq_o)
  );
endmodule

// File: tb/gpio_edge_irq_bank_bench.sv
`timescale 1ns/1ps
module gpio_edge_irq_bank_bench;
  localparam int NP = 8;
  localparam int IW = $clog2(NP);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ms_tick = 1'b0;
  logic [NP-1:0] pin_raw = '0;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_pin = '0;
  logic [8:0]    cfg_word = '0;
  logic          stat_clr_we = 1'b0;
  logic [NP-1:0] stat_clr_bits = '0;
  logic          mask_set_we = 1'b0;
  logic [NP-1:0] mask_set_bits = '0;
  logic          mask_clr_we = 1'b0;
  logic [NP-1:0] mask_clr_bits = '0;
  logic [NP-1:0] status_o, mask_o;
  logic          irq_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  gpio_edge_irq_bank #(.NPINS(NP)) u_gpio_edge_irq_bank (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .pin_raw(pin_raw),
    .cfg_we(cfg_we), .cfg_pin(cfg_pin), .cfg_word(cfg_word),
    .stat_clr_we(stat_clr_we), .stat_clr_bits(stat_clr_bits),
    .mask_set_we(mask_set_we), .mask_set_bits(mask_set_bits),
    .mask_clr_we(mask_clr_we), .mask_clr_bits(mask_clr_bits),
    .status_o(status_o), .mask_o(mask_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // control word: bit 8 debounce on, 7:5 length, 4:3 edge, 2:0 filler (R2 says ignored)
  task automatic cfg(input int p, input int mode, input int den, input int n);
    cfg_we   = 1'b1;
    cfg_pin  = IW'(p);
    cfg_word = {den[0], n[2:0], mode[1:0], 3'b101};
    cyc(1);
    cfg_we   = 1'b0;
  endtask

  task automatic clr_all();
    stat_clr_we = 1'b1; stat_clr_bits = '1;
    cyc(1);
    stat_clr_we = 1'b0; stat_clr_bits = '0;
  endtask

  task automatic pulse();
    ms_tick = 1'b1; cyc(1);
    ms_tick = 1'b0; cyc(1);
  endtask

  task automatic mset(input logic [NP-1:0] b);
    mask_set_we = 1'b1; mask_set_bits = b; cyc(1);
    mask_set_we = 1'b0; mask_set_bits = '0;
  endtask

  task automatic mclr(input logic [NP-1:0] b);
    mask_clr_we = 1'b1; mask_clr_bits = b; cyc(1);
    mask_clr_we = 1'b0; mask_clr_bits = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lens [5];
    lens = '{0, 1, 2, 3, 7};
    cyc(4);
    rst = 1'b0;
    cyc(1);
    check("R1 status after reset", 32'(status_o), 32'h0);
    check("R1 mask after reset", 32'(mask_o), 32'((1 << NP) - 1));
    check("R1 irq after reset", 32'(irq_o), 32'h0);

    // edge selection sweep over all pins and codes, debounce off
    for (int p = 0; p < NP; p++) begin
      for (int m = 0; m < 4; m++) begin
        cfg(p, m, 0, 0);
        clr_all();
        pin_raw[p] = 1'b1;
        cyc(1);
        check("R3 no status one edge after change", 32'(status_o), 32'h0);
        cyc(1);
        check("R2 rising edge code", 32'(status_o), ((m & 1) != 0) ? (32'h1 << p) : 32'h0);
        check("R7 masked pin keeps irq low", 32'(irq_o), 32'h0);
        clr_all();
        pin_raw[p] = 1'b0;
        cyc(2);
        check("R2 falling edge code", 32'(status_o), ((m & 2) != 0) ? (32'h1 << p) : 32'h0);
        clr_all();
        cyc(1);
      end
    end

    // R3 latch while masked, R7 unmask raises irq at once
    cfg(0, 3, 0, 0);
    pin_raw[0] = 1'b1;
    cyc(2);
    check("R3 status latched while masked", 32'(status_o), 32'h1);
    check("R3 irq stays low while masked", 32'(irq_o), 32'h0);
    mclr(8'h01);
    check("R6 mask clear port", 32'(mask_o), 32'hFE);
    check("R7 irq rises with unmask", 32'(irq_o), 32'h1);
    mset(8'h01);
    check("R6 mask set port", 32'(mask_o), 32'hFF);
    check("R7 irq falls with mask", 32'(irq_o), 32'h0);
    mclr(8'h01);
    stat_clr_we = 1'b1; stat_clr_bits = 8'hFE; cyc(1); stat_clr_we = 1'b0;
    check("R4 zero bits leave status", 32'(status_o), 32'h1);
    check("R7 irq still high", 32'(irq_o), 32'h1);
    stat_clr_we = 1'b1; stat_clr_bits = 8'h01; cyc(1); stat_clr_we = 1'b0;
    check("R4 write one clears", 32'(status_o), 32'h0);
    check("R7 irq drops with clear", 32'(irq_o), 32'h0);

    // R6 both mask ports on one bit
    mclr(8'h04);
    check("R6 bit cleared before race", 32'(mask_o), 32'hFA);
    mask_set_we = 1'b1; mask_set_bits = 8'h14;
    mask_clr_we = 1'b1; mask_clr_bits = 8'h0C;
    cyc(1);
    mask_set_we = 1'b0; mask_clr_we = 1'b0;
    check("R6 set port wins", 32'(mask_o), 32'hF6);

    // R5 edge and clear on the same edge
    cfg(1, 1, 0, 0);
    pin_raw[1] = 1'b1;
    cyc(2);
    check("R5 pin1 pending before race", 32'(status_o), 32'h2);
    pin_raw[0] = 1'b0;
    cyc(1);
    stat_clr_we = 1'b1; stat_clr_bits = 8'h03;
    cyc(1);
    stat_clr_we = 1'b0; stat_clr_bits = '0;
    check("R5 edge survives coincident clear", 32'(status_o), 32'h1);
    check("R7 irq for unmasked pin0", 32'(irq_o), 32'h1);
    clr_all();
    pin_raw[1] = 1'b0;
    cyc(2);

    // R9 bypass ignores length code and ticks
    cfg(3, 1, 0, 5);
    pin_raw[3] = 1'b1;
    cyc(2);
    check("R9 bypass reacts without ticks", 32'(status_o), 32'h8);
    clr_all();

    // R8 debounce lengths
    foreach (lens[k]) begin
      int n;
      int len;
      n   = lens[k];
      len = 1 << n;
      cfg(2, 1, 1, n);
      clr_all();
      pin_raw[2] = 1'b1;
      cyc(20);
      check("R8 no change without ticks", 32'(status_o), 32'h0);
      for (int t = 1; t <= len; t++) begin
        pulse();
        if (t == len - 1 || t == len)
          check("R8 debounce tick count", 32'(status_o), (t == len) ? 32'h4 : 32'h0);
      end
      clr_all();
      pin_raw[2] = 1'b0;
      repeat (len) pulse();
      check("R8 filtered fall ignored by rise code", 32'(status_o), 32'h0);
      if (n >= 1) begin
        pin_raw[2] = 1'b1;
        repeat (len - 1) pulse();
        pin_raw[2] = 1'b0;
        pulse();
        pin_raw[2] = 1'b1;
        repeat (len - 1) pulse();
        check("R8 reversal restarts count", 32'(status_o), 32'h0);
        pulse();
        check("R8 full run after restart", 32'(status_o), 32'h4);
        clr_all();
        pin_raw[2] = 1'b0;
        repeat (len) pulse();
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule